// File: doc/BRIEF.md
# Integer ALU for a load-store RISC core

This block is the combinational integer arithmetic and logic unit of a load-store RISC pipeline. It takes two operands and a 4-bit operation code. It returns a result word, a flag that is high when the result is all zeros, and a signed overflow flag. The execute stage uses the result for register writeback. A branch-on-equal decision is the zero flag after a subtract.

All arithmetic passes through one ripple adder. Subtraction inverts B and forces the carry into bit 0. The two set-on-less-than forms are derived from the adder's difference, its carries and its sign bit. Sign or zero extension of immediates, shifting, multiply and divide are handled outside the block.

The operand width is a parameter. The default is 32.

Top module: `alu_core`

## Requirements
- R1: Operation codes 0010 (signed add) and 0011 (unsigned add) give `result_o` = A + B modulo 2^WIDTH.
- R2: Operation codes 0110 (signed subtract) and 1000 (unsigned subtract) give `result_o` = A − B modulo 2^WIDTH. The difference is formed as A + ~B + 1.
- R3: For 0010 and 0110, `ovf_o` is the carry into the top bit XOR the carry out of the top bit. It is therefore high exactly when the true signed result does not fit in WIDTH bits.
- R4: Codes 0011, 1000 and 1001 never raise `ovf_o`.
- R5: Codes 0000 (and), 0001 (or), 0100 (xor) and 0101 (nor) give the bitwise function of A and B.
- R6: Code 0111 (signed less-than) puts 1 in bit 0 when A < B as two's-complement values, and 0 otherwise. This holds even when A − B overflows. All other result bits are 0.
- R7: Code 1001 (unsigned less-than) puts 1 in bit 0 exactly when A < B as unsigned values, which is when A − B has no carry out of the top bit. All other result bits are 0.
- R8: `zero_o` is 1 exactly when every bit of `result_o` is 0. After a subtract, it is high exactly when A equals B.
- R9: Codes 1010 to 1111 give a result of 0 with `ovf_o` low.
- R10: `ovf_o` is 0 for the four bitwise codes and both less-than codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow on signed add or subtract |

## Verification
A 4-bit instance is swept over every operation code and every operand pair. This covers:
- each carry-into and carry-out combination at the top bit, which separates true overflow from a sign change alone;
- the signed and unsigned orderings of every pair, which tells the two less-than forms apart;
- every equal pair, which exercises the zero flag.

The 32-bit default instance is then driven with directed boundary pairs:
- maximum positive plus one;
- minimum negative minus one;
- minimum negative against maximum positive, for both comparisons;
- equal operands.

These separate the signed forms from the unsigned ones at full width. Random operand pairs for all sixteen codes follow. All of these are checked against an arithmetic model in the bench that uses 64-bit integers.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_ADDU = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_NOR  = 4'b0101,
    OP_SUB  = 4'b0110,
    OP_SLT  = 4'b0111,
    OP_SUBU = 4'b1000,
    OP_SLTU = 4'b1001
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_SUM   = 2'd2,
    SRC_LESS  = 2'd3
  } res_src_e;

  typedef struct packed {
    logic      sub;       // invert B, carry-in 1
    logic      chk_ovf;   // signed variant: report overflow
    logic      less_uns;  // less-than uses unsigned ordering
    logic_fn_e lfn;
    res_src_e  src;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{sub: 1'b0, chk_ovf: 1'b0, less_uns: 1'b0, lfn: LG_AND, src: SRC_NONE};
    case (op_i)
      OP_AND:  begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LG_AND; end
      OP_OR:   begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LG_OR;  end
      OP_XOR:  begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LG_XOR; end
      OP_NOR:  begin ctrl_o.src = SRC_LOGIC; ctrl_o.lfn = LG_NOR; end
      OP_ADD:  begin ctrl_o.src = SRC_SUM;   ctrl_o.chk_ovf = 1'b1; end
      OP_ADDU: begin ctrl_o.src = SRC_SUM;   end
      OP_SUB:  begin ctrl_o.src = SRC_SUM;   ctrl_o.sub = 1'b1; ctrl_o.chk_ovf = 1'b1; end
      OP_SUBU: begin ctrl_o.src = SRC_SUM;   ctrl_o.sub = 1'b1; end
      OP_SLT:  begin ctrl_o.src = SRC_LESS;  ctrl_o.sub = 1'b1; end
      OP_SLTU: begin ctrl_o.src = SRC_LESS;  ctrl_o.sub = 1'b1; ctrl_o.less_uns = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_msb_o,  // carry into top bit
  output logic             c_out_o   // carry out of top bit
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carry;

  assign b_eff = b_i ^ {WIDTH{sub_i}};

  always_comb begin
    carry[0] = sub_i;
    for (int i = 0; i < int'(WIDTH); i++) begin
      sum_o[i]     = a_i[i] ^ b_eff[i] ^ carry[i];
      carry[i+1]   = (a_i[i] & b_eff[i]) | (a_i[i] & carry[i]) | (b_eff[i] & carry[i]);
    end
  end

  assign c_msb_o = carry[WIDTH-1];
  assign c_out_o = carry[WIDTH];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_fn_e        fn_i,
  output logic [WIDTH-1:0] y_o
);

  logic [WIDTH-1:0] g_and, g_or, g_xor, g_nor;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign g_and[i] = a_i[i] & b_i[i];
    assign g_or[i]  = a_i[i] | b_i[i];
    assign g_xor[i] = a_i[i] ^ b_i[i];
    assign g_nor[i] = ~(a_i[i] | b_i[i]);
  end

  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = g_and;
      LG_OR:   y_o = g_or;
      LG_XOR:  y_o = g_xor;
      default: y_o = g_nor;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum, lres;
  logic             c_msb, c_out, ovf_raw, less_s, less_u, less_bit;

  alu_decode i_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  alu_adder #(.WIDTH(WIDTH)) i_adder (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (ctrl.sub),
    .sum_o   (sum),
    .c_msb_o (c_msb),
    .c_out_o (c_out)
  );

  alu_logic #(.WIDTH(WIDTH)) i_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (ctrl.lfn),
    .y_o  (lres)
  );

  assign ovf_raw  = c_msb ^ c_out;
  assign less_s   = sum[MSB] ^ ovf_raw;   // sign corrected for overflow
  assign less_u   = ~c_out;               // borrow out
  assign less_bit = ctrl.less_uns ? less_u : less_s;

  always_comb begin
    unique case (ctrl.src)
      SRC_LOGIC: result_o = lres;
      SRC_SUM:   result_o = sum;
      SRC_LESS:  result_o = {{(WIDTH-1){1'b0}}, less_bit};
      default:   result_o = '0;
    endcase
  end

  assign ovf_o  = ctrl.chk_ovf & ovf_raw;
  assign zero_o = ~|result_o;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;
  logic [WIDTH-1:0] rebuilt;

  assign rebuilt = result_o + b_i;

  always_comb begin
    if (op_i == 4'b0110 || op_i == 4'b1000)
      p_sub_diff_r2: assert (rebuilt == a_i);
    if (op_i == 4'b0010 && ovf_o)
      p_ovf_sign_r3: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB]);
    if (op_i == 4'b0011 || op_i == 4'b1000 || op_i == 4'b1001)
      p_no_overflow_r4: assert (!ovf_o);
    if (op_i == 4'b0111 || op_i == 4'b1001)
      p_less_upper_r6: assert (result_o[MSB:1] == '0);
    if (op_i == 4'b0110)
      p_zero_eq_r8: assert (zero_o == (a_i == b_i));
    if (op_i > 4'b1001)
      p_undef_quiet_r9: assert (result_o == '0 && !ovf_o && zero_o);
    if (op_i == 4'b0000 || op_i == 4'b0001 || op_i == 4'b0100 ||
        op_i == 4'b0101 || op_i == 4'b0111)
      p_ovf_quiet_r10: assert (!ovf_o);
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .op_i     (op_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .ovf_o    (ovf_o)
);

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [3:0]  op32, a4, b4, op4, r4;
  logic        z32, v32, z4, v4;

  alu_core #(.WIDTH(32)) i_alu_core (
    .a_i(a32), .b_i(b32), .op_i(op32), .result_o(r32), .zero_o(z32), .ovf_o(v32)
  );

  alu_core #(.WIDTH(4)) i_alu_core_w4 (
    .a_i(a4), .b_i(b4), .op_i(op4), .result_o(r4), .zero_o(z4), .ovf_o(v4)
  );

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd4, 4'd5: return "R5";
      4'd2, 4'd3:             return "R1";
      4'd6, 4'd8:             return "R2";
      4'd7:                   return "R6";
      4'd9:                   return "R7";
      default:                return "R9";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [3:0] op);
    case (op)
      4'd2, 4'd6:       return "R3";
      4'd3, 4'd8, 4'd9: return "R4";
      4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: return "R9";
      default:          return "R10";
    endcase
  endfunction

  // arithmetic model from the requirements
  task automatic model(input int w, input logic [3:0] op,
                       input longint unsigned a, input longint unsigned b,
                       output longint unsigned r, output bit v);
    longint unsigned mask = (64'd1 << w) - 1;
    longint          half = longint'(64'd1 << (w - 1));
    longint          sa   = longint'(a ^ 64'(half)) - half;
    longint          sb   = longint'(b ^ 64'(half)) - half;
    longint          s;
    r = 0; v = 0;
    case (op)
      4'd0: r = a & b;
      4'd1: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = ~(a | b) & mask;
      4'd2, 4'd3: begin
        r = (a + b) & mask; s = sa + sb;
        v = (op == 4'd2) && (s >= half || s < -half);
      end
      4'd6, 4'd8: begin
        r = (a - b) & mask; s = sa - sb;
        v = (op == 4'd6) && (s >= half || s < -half);
      end
      4'd7: r = (sa < sb) ? 1 : 0;
      4'd9: r = (a < b) ? 1 : 0;
      default: r = 0;
    endcase
  endtask

  task automatic compare(input int w, input logic [3:0] op, input longint unsigned a,
                         input longint unsigned b, input longint unsigned r,
                         input bit z, input bit v);
    longint unsigned er;
    bit ev;
    model(w, op, a, b, er, ev);
    n_tests++;
    if (r != er) begin
      n_fail++;
      $display("FAIL %s w=%0d op=%0d a=%h b=%h result act=%h exp=%h", res_tag(op), w, op, a, b, r, er);
    end
    n_tests++;
    if (v != ev) begin
      n_fail++;
      $display("FAIL %s w=%0d op=%0d a=%h b=%h ovf act=%0d exp=%0d", ovf_tag(op), w, op, a, b, v, ev);
    end
    n_tests++;
    if (z != (er == 0)) begin
      n_fail++;
      $display("FAIL R8 w=%0d op=%0d a=%h b=%h zero act=%0d exp=%0d", w, op, a, b, z, (er == 0));
    end
  endtask

  task automatic run32(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op32 = op; a32 = a; b32 = b;
    #1;
    compare(32, op, a, b, r32, z32, v32);
  endtask

  initial begin
    a32 = '0; b32 = '0; op32 = '0; a4 = '0; b4 = '0; op4 = '0;
    #1;
    // initial state: and of zeros
    compare(32, 4'd0, 0, 0, r32, z32, v32);

    // exhaustive 4-bit sweep: R1..R10
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          op4 = 4'(op); a4 = 4'(a); b4 = 4'(b);
          #1;
          compare(4, 4'(op), 64'(a), 64'(b), 64'(r4), z4, v4);
        end

    // R3/R4: max positive plus one
    run32(4'd2, 32'h7fff_ffff, 32'd1);
    run32(4'd3, 32'h7fff_ffff, 32'd1);
    // R3/R4: min negative minus one
    run32(4'd6, 32'h8000_0000, 32'd1);
    run32(4'd8, 32'h8000_0000, 32'd1);
    // R6/R7: min negative against max positive, both directions
    run32(4'd7, 32'h8000_0000, 32'h7fff_ffff);
    run32(4'd9, 32'h8000_0000, 32'h7fff_ffff);
    run32(4'd7, 32'h7fff_ffff, 32'h8000_0000);
    run32(4'd9, 32'h7fff_ffff, 32'h8000_0000);
    // R8: equal operands
    run32(4'd6, 32'hdead_beef, 32'hdead_beef);
    run32(4'd7, 32'h1234_5678, 32'h1234_5678);
    run32(4'd9, 32'hffff_ffff, 32'hffff_ffff);
    // R9: undefined codes with nonzero operands
    run32(4'd10, 32'hffff_ffff, 32'h1);
    run32(4'd15, 32'h8000_0000, 32'h8000_0000);

    // random operands, all codes
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 400; k++)
        run32(4'(op), $urandom, (k % 8 == 0) ? 32'h8000_0000 : $urandom);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule